// File: doc/BRIEF.md
# Interrupter Delivery Selector

This block sits between the interrupters of a host controller and a PCI endpoint's interrupt logic. Each interrupter has a level; a raise pulse asks the block to deliver that interrupter's current level. The block turns each request into exactly one outcome: a message on the extended message-signalled path, a message on the plain message-signalled path, or nothing. Independently, it drives the legacy interrupt pin from interrupter 0 whenever neither message path is enabled.

Requests raised in the same cycle are queued and served one per cycle, lowest index first. Vector numbers on the plain message path are folded into the allocated vector count, which is a power of two. The block also holds a per-interrupter flag recording whether the interrupter's extended-message vector is claimed. It drives a mapping-allowed output that, when the conditional option is set, tells the controller to keep all events on interrupter 0 while only the pin is available.

Top module: `intr_route`

## Requirements
- R1: `intxOut` equals, one cycle later, `intrLevel[0]` while `msiEn` and `msixEn` are both 0, and is 0 one cycle after either enable is 1.
- R2: The level of any interrupter other than 0 never affects `intxOut`.
- R3: A request served with `msixEn`=1 and a high level gives a one-cycle `msixSend` with `msixVec` equal to the interrupter index, and `accepted`=1. All served outputs appear in the cycle after the clock edge at which the request is taken.
- R4: With `msixEn` and `msiEn` both 1, only `msixSend` pulses; `msiSend` stays 0.
- R5: A request served with only `msiEn`=1 and a high level gives a one-cycle `msiSend` and `accepted`=1, with `msiVec` = index modulo 2^`msiLog2` (`msiLog2` 0..5 means 1..32 vectors; values above 5 act as 5).
- R6: A served request with a low level, or with both enables 0, gives `serveValid`=1, `accepted`=0, and no message strobe.
- R7: `mapAllowed` is 1 when `condMap`=0, and equals `msiEn | msixEn` when `condMap`=1.
- R8: A `useReq` pulse sets bit `useIdx` of `msixInUse` to `useOn` only while `msixEn`=1, and `useChg` pulses for one cycle when the bit flips. With `msixEn`=0 the request leaves the bits unchanged and gives no `useChg`.
- R9: A `useReq` whose `useOn` equals the current flag gives no `useChg` and leaves the flag unchanged.
- R10: Raise pulses arriving together are served one per cycle in ascending index order. Unserved ones stay pending and produce no further `serveValid` once all are served.
- R11: Synchronous active-high `rst` clears pending requests, `msixInUse`, all strobes and `intxOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intrLevel | input | NUM_INTR | Current level of each interrupter |
| raiseReq | input | NUM_INTR | Pulse per interrupter requesting delivery |
| msiEn | input | 1 | Plain message path enabled |
| msixEn | input | 1 | Extended message path enabled |
| msiLog2 | input | 3 | Log2 of allocated plain-message vectors |
| condMap | input | 1 | Conditional mapping option |
| useReq | input | 1 | In-use flag update pulse |
| useIdx | input | IDX_W | Interrupter whose flag is updated |
| useOn | input | 1 | New flag value |
| intxOut | output | 1 | Legacy interrupt pin level |
| serveValid | output | 1 | A request was served this cycle |
| serveIdx | output | IDX_W | Index of the served request |
| accepted | output | 1 | Served request was delivered as a message |
| msixSend | output | 1 | Extended message strobe |
| msixVec | output | IDX_W | Extended message vector |
| msiSend | output | 1 | Plain message strobe |
| msiVec | output | IDX_W | Plain message vector (folded) |
| useChg | output | 1 | An in-use flag flipped |
| msixInUse | output | NUM_INTR | Per-interrupter in-use flags |
| mapAllowed | output | 1 | Interrupter mapping permitted |

## Verification
The bench targets precedence with both message paths on; a design that checked the plain path first would pulse `msiSend` and leave `msixSend` low. It sweeps the fold over 1, 4 and 32 vectors with index 13. Wrong masking shows up as vector 13 where 1 is expected, or as a nonzero vector with one vector allocated. It raises three interrupters at once and expects them served in order on consecutive cycles; a design that dropped the losers would go idle after the first. In-use updates are sent with the extended path off and as repeats, where a careless design would flip the bit or pulse `useChg`. A reset taken in the middle of a queue must leave nothing to serve.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
  // Strobes passed from arbitration control to the delivery datapath
  typedef struct packed {
    logic serve;  // a request is taken this cycle
    logic level;  // sampled level of the taken interrupter
  } ctrlStrb_t;

  localparam int unsigned MAX_MSI_LOG2 = 5;
endpackage

// File: rtl/intr_route_ctrl.sv
module intr_route_ctrl
  import intr_route_pkg::*;
#(
  parameter int unsigned NUM_INTR = 16,
  localparam int unsigned IDX_W = (NUM_INTR > 1) ? $clog2(NUM_INTR) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_INTR-1:0] intrLevel,
  input  logic [NUM_INTR-1:0] raiseReq,
  output ctrlStrb_t           strb,
  output logic [IDX_W-1:0]    pickIdx
);
  logic [NUM_INTR-1:0] pendQ;
  logic [NUM_INTR-1:0] merged;
  logic [NUM_INTR-1:0] grantOh;

  assign merged = pendQ | raiseReq;

  // lowest index wins
  always_comb begin
    pickIdx = '0;
    grantOh = '0;
    for (int i = NUM_INTR - 1; i >= 0; i--) begin
      if (merged[i]) begin
        pickIdx = IDX_W'(i);
        grantOh = '0;
        grantOh[i] = 1'b1;
      end
    end
    strb.serve = |merged;
    strb.level = intrLevel[pickIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) pendQ <= '0;
    else     pendQ <= merged & ~grantOh;
  end
endmodule

// File: rtl/intr_route_dp.sv
module intr_route_dp
  import intr_route_pkg::*;
#(
  parameter int unsigned NUM_INTR = 16,
  localparam int unsigned IDX_W = (NUM_INTR > 1) ? $clog2(NUM_INTR) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrb_t           strb,
  input  logic [IDX_W-1:0]    pickIdx,
  input  logic                lvl0,
  input  logic                msiEn,
  input  logic                msixEn,
  input  logic [2:0]          msiLog2,
  input  logic                useReq,
  input  logic [IDX_W-1:0]    useIdx,
  input  logic                useOn,
  output logic                intxOut,
  output logic                serveValid,
  output logic [IDX_W-1:0]    serveIdx,
  output logic                accepted,
  output logic                msixSend,
  output logic [IDX_W-1:0]    msixVec,
  output logic                msiSend,
  output logic [IDX_W-1:0]    msiVec,
  output logic                useChg,
  output logic [NUM_INTR-1:0] msixInUse
);
  logic [2:0]       lgEff;
  logic [IDX_W-1:0] foldMask;
  logic             anyMsg;

  assign lgEff  = (msiLog2 > 3'(MAX_MSI_LOG2)) ? 3'(MAX_MSI_LOG2) : msiLog2;
  assign anyMsg = msiEn | msixEn;

  generate
    for (genvar b = 0; b < IDX_W; b++) begin : g_mask
      assign foldMask[b] = (b < int'(lgEff));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      intxOut    <= 1'b0;
      serveValid <= 1'b0;
      serveIdx   <= '0;
      accepted   <= 1'b0;
      msixSend   <= 1'b0;
      msixVec    <= '0;
      msiSend    <= 1'b0;
      msiVec     <= '0;
    end else begin
      intxOut    <= lvl0 & ~anyMsg;
      serveValid <= strb.serve;
      serveIdx   <= pickIdx;
      accepted   <= strb.serve & strb.level & anyMsg;
      msixSend   <= strb.serve & strb.level & msixEn;
      msiSend    <= strb.serve & strb.level & msiEn & ~msixEn;
      msixVec    <= pickIdx;
      msiVec     <= pickIdx & foldMask;
    end
  end

  // in-use flags for extended message vectors
  always_ff @(posedge clk) begin
    if (rst) begin
      msixInUse <= '0;
      useChg    <= 1'b0;
    end else begin
      useChg <= 1'b0;
      if (useReq && msixEn && (int'(useIdx) < NUM_INTR)
          && (msixInUse[useIdx] != useOn)) begin
        msixInUse[useIdx] <= useOn;
        useChg            <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_route.sv
module intr_route
  import intr_route_pkg::*;
#(
  parameter int unsigned NUM_INTR = 16,
  localparam int unsigned IDX_W = (NUM_INTR > 1) ? $clog2(NUM_INTR) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_INTR-1:0] intrLevel,
  input  logic [NUM_INTR-1:0] raiseReq,
  input  logic                msiEn,
  input  logic                msixEn,
  input  logic [2:0]          msiLog2,
  input  logic                condMap,
  input  logic                useReq,
  input  logic [IDX_W-1:0]    useIdx,
  input  logic                useOn,
  output logic                intxOut,
  output logic                serveValid,
  output logic [IDX_W-1:0]    serveIdx,
  output logic                accepted,
  output logic                msixSend,
  output logic [IDX_W-1:0]    msixVec,
  output logic                msiSend,
  output logic [IDX_W-1:0]    msiVec,
  output logic                useChg,
  output logic [NUM_INTR-1:0] msixInUse,
  output logic                mapAllowed
);
  ctrlStrb_t        strb;
  logic [IDX_W-1:0] pickIdx;

  assign mapAllowed = ~condMap | msiEn | msixEn;

  intr_route_ctrl #(.NUM_INTR(NUM_INTR)) u_ctrl (
    .clk(clk), .rst(rst), .intrLevel(intrLevel), .raiseReq(raiseReq),
    .strb(strb), .pickIdx(pickIdx)
  );

  intr_route_dp #(.NUM_INTR(NUM_INTR)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .pickIdx(pickIdx),
    .lvl0(intrLevel[0]), .msiEn(msiEn), .msixEn(msixEn), .msiLog2(msiLog2),
    .useReq(useReq), .useIdx(useIdx), .useOn(useOn),
    .intxOut(intxOut), .serveValid(serveValid), .serveIdx(serveIdx),
    .accepted(accepted), .msixSend(msixSend), .msixVec(msixVec),
    .msiSend(msiSend), .msiVec(msiVec), .useChg(useChg),
    .msixInUse(msixInUse)
  );
endmodule

// File: rtl/intr_route_chk.sv
module intr_route_chk #(
  parameter int unsigned NUM_INTR = 16,
  localparam int unsigned IDX_W = (NUM_INTR > 1) ? $clog2(NUM_INTR) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_INTR-1:0] intrLevel,
  input logic [NUM_INTR-1:0] raiseReq,
  input logic                msiEn,
  input logic                msixEn,
  input logic [2:0]          msiLog2,
  input logic                condMap,
  input logic                useReq,
  input logic [IDX_W-1:0]    useIdx,
  input logic                useOn,
  input logic                intxOut,
  input logic                serveValid,
  input logic [IDX_W-1:0]    serveIdx,
  input logic                accepted,
  input logic                msixSend,
  input logic [IDX_W-1:0]    msixVec,
  input logic                msiSend,
  input logic [IDX_W-1:0]    msiVec,
  input logic                useChg,
  input logic [NUM_INTR-1:0] msixInUse,
  input logic                mapAllowed
);
  a_r1_pin_off_with_msg: assert property (@(posedge clk) disable iff (rst)
    (msiEn || msixEn) |=> !intxOut);

  a_r1_pin_follows_lvl0: assert property (@(posedge clk) disable iff (rst)
    (intrLevel[0] && !msiEn && !msixEn) |=> intxOut);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(msixSend && msiSend));

  a_r6_strobe_needs_accept: assert property (@(posedge clk) disable iff (rst)
    (msixSend || msiSend) |-> (accepted && serveValid));

  a_r7_map_no_cond: assert property (@(posedge clk) disable iff (rst)
    !condMap |-> mapAllowed);

  a_r8_flags_frozen: assert property (@(posedge clk) disable iff (rst)
    !msixEn |=> ($stable(msixInUse) && !useChg));

  a_r3_vec_is_idx: assert property (@(posedge clk) disable iff (rst)
    msixSend |-> (msixVec == serveIdx));
endmodule

bind intr_route intr_route_chk #(.NUM_INTR(NUM_INTR)) u_chk (.*);

// File: tb/intr_route_test.sv
`timescale 1ns/1ps
module intr_route_test;
  localparam int N = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  intrLevel, raiseReq, msixInUse;
  logic          msiEn, msixEn, condMap, useReq, useOn;
  logic [2:0]    msiLog2;
  logic [IW-1:0] useIdx, serveIdx, msixVec, msiVec;
  logic          intxOut, serveValid, accepted, msixSend, msiSend, useChg, mapAllowed;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  intr_route #(.NUM_INTR(N)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    raiseReq = '0;
    useReq   = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 intx", intxOut, 0);
    chk("R11 serveValid", serveValid, 0);
    chk("R11 inUse", int'(msixInUse), 0);
  endtask

  task automatic t_pin();
    msiEn = 0; msixEn = 0;
    intrLevel = 16'h0001;
    tick();
    chk("R1 pin follows lvl0 high", intxOut, 1);
    intrLevel = 16'h0008;
    tick();
    chk("R2 other interrupter no pin", intxOut, 0);
    intrLevel = 16'hFFFE;
    tick();
    chk("R2 all others high no pin", intxOut, 0);
    intrLevel = 16'h0001; msiEn = 1;
    tick();
    chk("R1 pin off with msi", intxOut, 0);
    msiEn = 0; msixEn = 1;
    tick();
    chk("R1 pin off with msix", intxOut, 0);
    msixEn = 0; intrLevel = '0;
    tick();
  endtask

  task automatic t_msix();
    msixEn = 1; msiEn = 1; intrLevel = 16'h0020;
    raiseReq = 16'h0020;
    tick();
    chk("R3 msixSend", msixSend, 1);
    chk("R3 msixVec", int'(msixVec), 5);
    chk("R3 accepted", accepted, 1);
    chk("R4 msi suppressed", msiSend, 0);
    tick();
    chk("R3 one-cycle strobe", msixSend, 0);
    msiEn = 0; msixEn = 0; intrLevel = '0;
  endtask

  task automatic t_msi(input int lg, input int idx, input int expVec);
    msiEn = 1; msixEn = 0; msiLog2 = 3'(lg);
    intrLevel = '0; intrLevel[idx] = 1'b1;
    raiseReq = '0; raiseReq[idx] = 1'b1;
    tick();
    chk("R5 msiSend", msiSend, 1);
    chk("R5 msiVec fold", int'(msiVec), expVec);
    chk("R5 accepted", accepted, 1);
    chk("R5 no msix", msixSend, 0);
    msiEn = 0; intrLevel = '0;
  endtask

  task automatic t_reject();
    msixEn = 1; intrLevel = '0; raiseReq = 16'h0004;
    tick();
    chk("R6 low level served", serveValid, 1);
    chk("R6 low level not accepted", accepted, 0);
    chk("R6 low level no strobe", msixSend, 0);
    msixEn = 0; intrLevel = 16'h0004; raiseReq = 16'h0004;
    tick();
    chk("R6 no path not accepted", accepted, 0);
    chk("R6 no path no msi", msiSend, 0);
    intrLevel = '0;
  endtask

  task automatic t_map();
    condMap = 1; msiEn = 0; msixEn = 0;
    #1 chk("R7 cond off-paths", mapAllowed, 0);
    msiEn = 1;
    #1 chk("R7 cond with msi", mapAllowed, 1);
    msiEn = 0; msixEn = 1;
    #1 chk("R7 cond with msix", mapAllowed, 1);
    msixEn = 0; condMap = 0;
    #1 chk("R7 no cond", mapAllowed, 1);
  endtask

  task automatic t_inuse();
    msixEn = 0; useReq = 1; useIdx = 4'd2; useOn = 1;
    tick();
    chk("R8 ignored when disabled", int'(msixInUse), 0);
    chk("R8 no chg when disabled", useChg, 0);
    msixEn = 1; useReq = 1; useIdx = 4'd2; useOn = 1;
    tick();
    chk("R8 flag set", int'(msixInUse), 4);
    chk("R8 chg pulse", useChg, 1);
    useReq = 1; useIdx = 4'd2; useOn = 1;
    tick();
    chk("R9 repeat no chg", useChg, 0);
    chk("R9 repeat flag kept", int'(msixInUse), 4);
    msixEn = 0; useReq = 1; useIdx = 4'd2; useOn = 0;
    tick();
    chk("R8 clear ignored when disabled", int'(msixInUse), 4);
    msixEn = 1; useReq = 1; useIdx = 4'd2; useOn = 0;
    tick();
    chk("R8 flag cleared", int'(msixInUse), 0);
    chk("R8 chg on clear", useChg, 1);
    msixEn = 0;
  endtask

  task automatic t_arb();
    msixEn = 1; intrLevel = 16'hFFFF;
    raiseReq = 16'h0212;
    tick();
    chk("R10 first idx1", int'(serveIdx), 1);
    chk("R10 first valid", serveValid, 1);
    tick();
    chk("R10 second idx4", int'(serveIdx), 4);
    tick();
    chk("R10 third idx9", int'(serveIdx), 9);
    chk("R10 third vec", int'(msixVec), 9);
    tick();
    chk("R10 queue empty", serveValid, 0);
    // reset in the middle of a queue
    msixEn = 1; useReq = 1; useIdx = 4'd7; useOn = 1;
    raiseReq = 16'h00C0;
    tick();
    chk("R10 idx6 first", int'(serveIdx), 6);
    doReset();
    tick();
    chk("R11 pending cleared", serveValid, 0);
    chk("R11 inUse cleared", int'(msixInUse), 0);
    msixEn = 0; intrLevel = '0;
  endtask

  initial begin
    rst = 1; intrLevel = '0; raiseReq = '0; msiEn = 0; msixEn = 0;
    msiLog2 = 3'd0; condMap = 0; useReq = 0; useIdx = '0; useOn = 0;
    doReset();
    t_reset();
    t_pin();
    t_msix();
    t_msi(2, 13, 1);
    t_msi(0, 13, 0);
    t_msi(5, 13, 13);
    t_msi(7, 11, 11);
    t_reject();
    t_map();
    t_inuse();
    t_arb();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule